// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches a group of asynchronous status lines, such as modem handshake signals or a line-break detector, and asks the CPU for service when an enabled line changes. When it sees a change, it freezes a snapshot of all lines and raises an interrupt request. The snapshot stays on the read port until the CPU acknowledges it with a one-cycle clear command. A pulse that is too short for software to poll is therefore still visible later in the snapshot.

After the clear, the block does not simply rearm. It compares the current synchronized lines against the snapshot it was holding. Any enabled line that still differs raises the next interrupt one cycle later. This gives a one-deep queue. A line that changed while the first event was pending, and kept its new level, is reported after the clear. A line that changed and then went back before the clear is not reported.

Top module: `extstat_irq_latch`

## Requirements
- R1: After synchronous reset, with all status inputs low, `irq` is 0 and `stat_rd` is all zeros.
- R2: When an enabled input changes while no interrupt is pending, `irq` goes high after the third rising clock edge, counting the edge that first samples the new level as the first edge.
- R3: A change on an input whose `stat_en` bit is 0 never raises `irq`. While no interrupt is pending, `stat_rd` still shows that input's synchronized level, with the same three-edge latency.
- R4: While `irq` is high and `clr_cmd` is low, `stat_rd` holds the values captured when the interrupt was raised, whatever the inputs do.
- R5: An enabled input that holds a new level across one sampling edge is captured while no interrupt is pending. `irq` rises, and the snapshot in `stat_rd` shows the pulse level after the input has returned.
- R6: `clr_cmd` sampled high while `irq` is high makes `irq` low after that edge. If the live inputs then match the snapshot on all enabled bits, `irq` stays low.
- R7: If, after a clear, the live synchronized inputs differ from the snapshot on an enabled bit, `irq` is low for exactly one cycle and then goes high again. The new snapshot holds the live values.
- R8: An enabled input that changes and then returns to its earlier level while `irq` is high produces no interrupt after the clear.
- R9: `clr_cmd` sampled while `irq` is low has no effect. A later enabled change still raises `irq` per R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_in | input | N_SRC | Asynchronous status lines |
| stat_en | input | N_SRC | Per-line enable for change interrupts |
| clr_cmd | input | 1 | One-cycle acknowledge that releases the snapshot |
| irq | output | 1 | Interrupt request, high while a snapshot is held |
| stat_rd | output | N_SRC | Snapshot while pending, otherwise live synchronized lines |

## Verification
An input change takes three edges to show up: two synchronizer stages and the snapshot stage. Both `irq` and the live value on `stat_rd` appear after the third edge. The effect of `clr_cmd` shows up on the very next edge. A queued re-raise shows up one edge after that. The bench drives every input on the falling edge and samples on the falling edge. Each directed check steps exactly the number of rising edges named in the requirement before comparing. In the random phase, a bench reference model advances on the same rising edges as the design, so its expected values line up cycle for cycle.

// File: rtl/esl_pkg.sv
package esl_pkg;
  // Latch state: following live inputs, or holding a snapshot.
  typedef enum logic {
    ST_TRACK = 1'b0,
    ST_HELD  = 1'b1
  } esl_state_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] d_in,
  output logic [N_SRC-1:0] q_out
);
  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_in[g]};
      end
      assign q_out[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/esl_change_det.sv
module esl_change_det #(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] live,
  input  logic [N_SRC-1:0] base,
  input  logic [N_SRC-1:0] en,
  output logic             hit
);
  logic [N_SRC-1:0] diff;
  always_comb begin
    diff = (live ^ base) & en;
    hit  = |diff;
  end
endmodule

// File: rtl/esl_latch_core.sv
module esl_latch_core
  import esl_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] live,
  input  logic             hit,
  input  logic             clr,
  output logic [N_SRC-1:0] snap,
  output logic             held
);
  esl_state_e       state_q;
  logic [N_SRC-1:0] snap_q;

  // The snapshot follows the live lines while tracking and freezes once held.
  // A clear keeps the snapshot, so the next tracking cycle compares the
  // live lines against it; this is the one-deep queue.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_TRACK;
      snap_q  <= '0;
    end else begin
      unique case (state_q)
        ST_TRACK: begin
          snap_q <= live;
          if (hit) state_q <= ST_HELD;
        end
        ST_HELD: begin
          if (clr) state_q <= ST_TRACK;
        end
        default: state_q <= ST_TRACK;
      endcase
    end
  end

  assign snap = snap_q;
  assign held = (state_q == ST_HELD);
endmodule

// File: rtl/extstat_irq_latch.sv
module extstat_irq_latch #(
  parameter int unsigned N_SRC       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] stat_in,
  input  logic [N_SRC-1:0] stat_en,
  input  logic             clr_cmd,
  output logic             irq,
  output logic [N_SRC-1:0] stat_rd
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < esl_pkg::MIN_SYNC_STAGES) ? esl_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

  logic [N_SRC-1:0] live_s;
  logic [N_SRC-1:0] snap_s;
  logic             hit_s;
  logic             held_s;

  esl_sync #(.N_SRC(N_SRC), .STAGES(STAGES_EFF)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (stat_in),
    .q_out (live_s)
  );

  esl_change_det #(.N_SRC(N_SRC)) u_det (
    .live (live_s),
    .base (snap_s),
    .en   (stat_en),
    .hit  (hit_s)
  );

  esl_latch_core #(.N_SRC(N_SRC)) u_core (
    .clk  (clk),
    .rst  (rst),
    .live (live_s),
    .hit  (hit_s),
    .clr  (clr_cmd),
    .snap (snap_s),
    .held (held_s)
  );

  assign irq     = held_s;
  assign stat_rd = snap_s;
endmodule

// File: rtl/extstat_irq_chk.sv
module extstat_irq_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] stat_en,
  input logic             clr_cmd,
  input logic             irq,
  input logic [N_SRC-1:0] stat_rd
);
  // R2: a new request always comes with an enabled bit that differs from the previous read value
  a_r2_rise_has_change: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (((stat_rd ^ $past(stat_rd)) & $past(stat_en)) != '0));

  // R3: with no request before or after, enabled read bits do not move
  a_r3_no_silent_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(irq) && !irq) |-> (((stat_rd ^ $past(stat_rd)) & $past(stat_en)) == '0));

  // R4: the snapshot is frozen while pending and not cleared
  a_r4_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_cmd) |=> (irq && $stable(stat_rd)));

  // R6: a clear drops the request on the next edge
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (irq && clr_cmd) |=> !irq);
endmodule

bind extstat_irq_latch extstat_irq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .stat_en (stat_en),
  .clr_cmd (clr_cmd),
  .irq     (irq),
  .stat_rd (stat_rd)
);

// File: tb/tb_extstat_irq_latch.sv
`timescale 1ns/1ps
module tb_extstat_irq_latch;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] stat_in;
  logic [N-1:0] stat_en;
  logic         clr_cmd;
  logic         irq;
  logic [N-1:0] stat_rd;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  extstat_irq_latch #(.N_SRC(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .stat_in(stat_in), .stat_en(stat_en),
    .clr_cmd(clr_cmd), .irq(irq), .stat_rd(stat_rd)
  );

  // Reference model written from the requirements: three-edge visibility, freeze, queued compare.
  logic [N-1:0] m_s1, m_s2, m_snap;
  logic         m_pend;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_pend <= 1'b0;
    end else begin
      m_s1 <= stat_in;
      m_s2 <= m_s1;
      if (!m_pend) begin
        m_snap <= m_s2;
        if (((m_s2 ^ m_snap) & stat_en) != '0) m_pend <= 1'b1;
      end else if (clr_cmd) begin
        m_pend <= 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_pulse();
    clr_cmd = 1'b1;
    step(1);
    clr_cmd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; stat_in = '0; stat_en = '1; clr_cmd = 1'b0;
    step(4);
    rst = 1'b0;
    step(1);
    check("R1 irq", {3'b0, irq}, 4'h0);
    check("R1 stat_rd", stat_rd, 4'h0);

    // R2: three-edge latency
    stat_in = 4'b0001;
    step(2);
    check("R2 irq early", {3'b0, irq}, 4'h0);
    step(1);
    check("R2 irq", {3'b0, irq}, 4'h1);
    check("R2 stat_rd", stat_rd, 4'b0001);

    // R4 hold, then R6 clear and R7 queued re-raise
    stat_in = 4'b0011;
    step(3);
    check("R4 irq", {3'b0, irq}, 4'h1);
    check("R4 stat_rd", stat_rd, 4'b0001);
    clear_pulse();
    check("R6 irq after clear", {3'b0, irq}, 4'h0);
    step(1);
    check("R7 irq reissued", {3'b0, irq}, 4'h1);
    check("R7 stat_rd", stat_rd, 4'b0011);

    // R6 clear with no difference
    clear_pulse();
    step(2);
    check("R6 irq stays low", {3'b0, irq}, 4'h0);
    check("R6 stat_rd", stat_rd, 4'b0011);

    // R8 two transitions while pending
    stat_in = 4'b0111;
    step(3);
    check("R8 irq set", {3'b0, irq}, 4'h1);
    stat_in = 4'b1111;
    step(2);
    stat_in = 4'b0111;
    step(4);
    check("R4 stat_rd frozen", stat_rd, 4'b0111);
    clear_pulse();
    step(3);
    check("R8 no new irq", {3'b0, irq}, 4'h0);
    check("R8 stat_rd", stat_rd, 4'b0111);

    // R3 disabled line
    stat_en = 4'b1110;
    stat_in = 4'b0110;
    step(4);
    check("R3 irq", {3'b0, irq}, 4'h0);
    check("R3 stat_rd live", stat_rd, 4'b0110);
    stat_en = 4'b1111;

    // R9 clear while idle
    clear_pulse();
    check("R9 irq", {3'b0, irq}, 4'h0);
    stat_in = 4'b0100;
    step(3);
    check("R9 irq raised", {3'b0, irq}, 4'h1);
    check("R9 stat_rd", stat_rd, 4'b0100);
    clear_pulse();
    step(2);
    check("R9 irq low", {3'b0, irq}, 4'h0);

    // R5 one-cycle pulse
    stat_in = 4'b1100;
    step(1);
    stat_in = 4'b0100;
    step(2);
    check("R5 irq", {3'b0, irq}, 4'h1);
    check("R5 stat_rd", stat_rd, 4'b1100);
    step(3);
    check("R5 stat_rd held", stat_rd, 4'b1100);
    clear_pulse();
    step(1);
    check("R7 irq pulse gone", {3'b0, irq}, 4'h1);
    check("R7 stat_rd live", stat_rd, 4'b0100);
    clear_pulse();
    step(2);

    // Random phase against the model (R2, R4, R6, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) stat_in[$urandom % N] ^= 1'b1;
      clr_cmd = ($urandom % 6 == 0);
      if ($urandom % 50 == 0) stat_en = N'($urandom);
      step(1);
      check("R4 random stat_rd", stat_rd, m_snap);
      check("R7 random irq", {3'b0, irq}, {3'b0, m_pend});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule